// File: doc/BRIEF.md
# Interrupt Entry and Control Register Unit

This unit holds the interrupt control state of a small 32-bit RISC core and decides when the core must leave its instruction stream to serve an interrupt. It has 32 level-sensitive request lines. It latches them into a sticky pending register and masks that register with a per-line enable mask. When the global enable bit is set and at least one unmasked line is pending, it raises a one-cycle take strobe. That strobe tells the pipeline to redirect fetch to a single shared vector: the programmable exception base plus 0xC0.

In the cycle of the take strobe, the unit records the address of the next instruction as the exception return address. This is the value software sees in register 30. In the same cycle it saves the global enable into a saved-enable bit and clears the global enable, so handlers do not nest. A return-from-exception strobe restores the global enable from the saved copy and presents the stored return address as the branch target. Software reaches all state through a small select/data control-register port with a combinational read.

Top module: `irq_csr_unit`

## Requirements
- R1: An asserted request line sets its pending bit on the next clock edge. The bit stays set after the line falls, until software clears it.
- R2: A control write to the pending register (select 2) clears every pending bit whose write-data bit is 1. In that cycle the request lines are not sampled. A line that is still high sets its bit again on the following edge.
- R3: `take` is high in a cycle exactly when the global enable is 1 and the bitwise AND of the pending and mask registers is non-zero. It never stays high for two cycles in a row.
- R4: On the edge that ends a `take` cycle, the return address register loads `next_pc`, the saved-enable bit loads the current global enable, and the global enable clears.
- R5: While the global enable is 0, `take` stays low whatever is pending and unmasked.
- R6: `vec_addr` always equals the exception base register plus 0xC0.
- R7: A `eret` strobe in a cycle without `take` copies the saved-enable bit into the global enable, and takes precedence over a status write in that cycle. `eret_target` always shows the return address register.
- R8: While `rst_n` is low, the status, mask and pending registers read 0 and the base register reads `BASE_RESET` with its low 8 bits cleared.
- R9: The control read port `csr_rdata` shows, without a clock delay, the register picked by `csr_sel`: 0 status (bit 0 global enable, bit 1 saved enable), 1 mask, 2 pending, 3 exception base, 4 return address. Any other select reads 0. Writes to selects 0, 1, 3 and 4 load the write data.
- R10: If a status write lands in the same cycle as `take`, the entry wins. The saved enable gets the pre-write global enable, and the global enable ends up 0. A return-address write in a `take` cycle is likewise overridden by `next_pc`.
- R11: The exception base register ignores the low 8 bits of a write, and those bits always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NLINES | Level-sensitive interrupt requests |
| next_pc | input | XLEN | Address of the next instruction, captured on entry |
| eret | input | 1 | Return-from-exception strobe |
| csr_we | input | 1 | Control register write enable |
| csr_sel | input | SEL_W | Control register select |
| csr_wdata | input | XLEN | Control register write data |
| csr_rdata | output | XLEN | Control register read data (combinational) |
| take | output | 1 | Interrupt entry strobe to the pipeline |
| vec_addr | output | XLEN | Redirect target for an entry |
| eret_target | output | XLEN | Branch target for a return |

## Verification
The bench aims at the cycles where several updates collide. One is a pending clear while a line stays high: a design that merged the sample into the clear would never drop the bit. Another is a status write in the entry cycle: letting the write win would leave interrupts enabled inside the handler and allow nesting. A third is an unaligned base write: keeping the low bits would move the shared vector off its 0xC0 slot. Random traffic with returns and masked lines then checks that `take` fires only once per entry, and never while the global enable is clear.

// File: rtl/irq_csr_unit.sv
module irq_csr_unit #(
  parameter int NLINES = 32,
  parameter int XLEN = 32,
  parameter int SEL_W = 3,
  parameter int ALIGN_BITS = 8,
  parameter logic [XLEN-1:0] VEC_OFFSET = 'hC0,
  parameter logic [XLEN-1:0] BASE_RESET = 'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lines,
  input  logic [XLEN-1:0]   next_pc,
  input  logic              eret,
  input  logic              csr_we,
  input  logic [SEL_W-1:0]  csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              take,
  output logic [XLEN-1:0]   vec_addr,
  output logic [XLEN-1:0]   eret_target
);
  localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_MASK   = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_PEND   = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_BASE   = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_EPC    = SEL_W'(4);
  localparam logic [XLEN-1:0]  ALIGN_MASK = {XLEN{1'b1}} << ALIGN_BITS;

  logic              ie, eie;
  logic [NLINES-1:0] mask, pend;
  logic [XLEN-1:0]   base, epc;

  wire wr_status = csr_we && (csr_sel == SEL_STATUS);
  wire wr_mask   = csr_we && (csr_sel == SEL_MASK);
  wire wr_pend   = csr_we && (csr_sel == SEL_PEND);
  wire wr_base   = csr_we && (csr_sel == SEL_BASE);
  wire wr_epc    = csr_we && (csr_sel == SEL_EPC);

  assign take        = ie && |(pend & mask);
  assign vec_addr    = base + VEC_OFFSET;
  assign eret_target = epc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie  <= 1'b0;
      eie <= 1'b0;
    end else if (take) begin
      eie <= ie;
      ie  <= 1'b0;
    end else if (eret) begin
      ie <= eie;
    end else if (wr_status) begin
      ie  <= csr_wdata[0];
      eie <= csr_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      pend <= '0;
      base <= BASE_RESET & ALIGN_MASK;
      epc  <= '0;
    end else begin
      if (wr_mask) mask <= csr_wdata[NLINES-1:0];
      if (wr_pend) pend <= pend & ~csr_wdata[NLINES-1:0];
      else         pend <= pend | irq_lines;
      if (wr_base) base <= csr_wdata & ALIGN_MASK;
      if (take)        epc <= next_pc;
      else if (wr_epc) epc <= csr_wdata;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_sel)
      SEL_STATUS: csr_rdata = XLEN'({eie, ie});
      SEL_MASK:   csr_rdata = XLEN'(mask);
      SEL_PEND:   csr_rdata = XLEN'(pend);
      SEL_BASE:   csr_rdata = base;
      SEL_EPC:    csr_rdata = epc;
      default:    csr_rdata = '0;
    endcase
  end

  // R4 R10
  entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (eie && !ie));

  // R4
  entry_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc == $past(next_pc)));

  // R3 R5
  take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  // R7
  eret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !take) |=> (ie == $past(eie)));

  // R2
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend & $past(csr_wdata[NLINES-1:0])) == '0));

  // R11
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base |=> (base[ALIGN_BITS-1:0] == '0));
endmodule

// File: tb/test_irq_csr_unit.sv
module test_irq_csr_unit;
  localparam int CLK_P = 10;
  localparam logic [31:0] BASE_RST = 32'h0000_1F55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] irq_lines = '0, next_pc = '0, csr_wdata = '0;
  logic eret = 1'b0, csr_we = 1'b0;
  logic [2:0] csr_sel = '0;
  logic [31:0] csr_rdata, vec_addr, eret_target;
  logic take;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic m_ie = 0, m_eie = 0;
  logic [31:0] m_mask = 0, m_pend = 0, m_base = BASE_RST & 32'hFFFF_FF00, m_epc = 0;
  logic o_take;
  logic [31:0] o_rd;

  always #(CLK_P/2) clk = ~clk;

  irq_csr_unit #(.BASE_RESET(BASE_RST)) i_irq_csr_unit (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .next_pc(next_pc),
    .eret(eret), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .take(take), .vec_addr(vec_addr),
    .eret_target(eret_target));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] s);
    case (s)
      3'd0: return {30'd0, m_eie, m_ie};
      3'd1: return m_mask;
      3'd2: return m_pend;
      3'd3: return m_base;
      3'd4: return m_epc;
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input logic [31:0] irq, input logic we, input logic [2:0] sel,
                      input logic [31:0] wd, input logic er, input logic [31:0] npc);
    logic e_take;
    @(negedge clk);
    irq_lines = irq; csr_we = we; csr_sel = sel; csr_wdata = wd; eret = er; next_pc = npc;
    #1;
    e_take = m_ie && |(m_pend & m_mask);
    o_take = take;
    o_rd = csr_rdata;
    chk("R3 R5 take", 32'(take), 32'(e_take));
    chk("R9 rdata", csr_rdata, exp_rd(sel));
    chk("R6 vec_addr", vec_addr, m_base + 32'hC0);
    chk("R7 eret_target", eret_target, m_epc);
    @(posedge clk);
    if (e_take) begin m_eie = m_ie; m_ie = 1'b0; end
    else if (er) m_ie = m_eie;
    else if (we && sel == 3'd0) begin m_ie = wd[0]; m_eie = wd[1]; end
    if (we && sel == 3'd1) m_mask = wd;
    if (we && sel == 3'd2) m_pend = m_pend & ~wd; else m_pend = m_pend | irq;
    if (we && sel == 3'd3) m_base = wd & 32'hFFFF_FF00;
    if (e_take) m_epc = npc; else if (we && sel == 3'd4) m_epc = wd;
  endtask

  task automatic rd(input logic [2:0] sel);
    step(32'd0, 1'b0, sel, 32'd0, 1'b0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 5; s++) begin
      @(negedge clk); csr_sel = 3'(s); #1;
      chk("R8 reset value", csr_rdata,
          (s == 3) ? 32'h0000_1F00 : 32'd0);
      chk("R8 take in reset", 32'(take), 32'd0);
    end
    @(negedge clk); rst_n = 1'b1;

    step(0, 1'b1, 3'd3, 32'h1234_56FF, 1'b0, 0);
    rd(3'd3);
    chk("R11 base low bits", o_rd, 32'h1234_5600);
    chk("R6 vector", vec_addr, 32'h1234_56C0);

    step(32'h20, 1'b0, 3'd0, 0, 1'b0, 0);
    rd(3'd2); rd(3'd2);
    chk("R1 sticky pending", o_rd, 32'h20);

    step(32'h20, 1'b1, 3'd2, 32'h20, 1'b0, 0);
    step(32'h20, 1'b0, 3'd2, 0, 1'b0, 0);
    chk("R2 cleared", o_rd, 32'h0);
    rd(3'd2);
    chk("R2 reset by held line", o_rd, 32'h20);

    step(0, 1'b1, 3'd1, 32'h20, 1'b0, 0);
    step(0, 1'b1, 3'd0, 32'h1, 1'b0, 0);
    step(0, 1'b0, 3'd0, 0, 1'b0, 32'h0000_0100);
    chk("R3 take asserted", 32'(o_take), 32'd1);
    step(0, 1'b0, 3'd0, 0, 1'b0, 0);
    chk("R4 status after entry", o_rd, 32'h2);
    chk("R5 no take while disabled", 32'(o_take), 32'd0);
    chk("R4 return address", eret_target, 32'h100);

    step(0, 1'b1, 3'd0, 32'h0, 1'b1, 0);
    chk("R7 target", eret_target, 32'h100);
    step(0, 1'b1, 3'd0, 32'h1, 1'b0, 32'h0000_0200);
    chk("R10 take with write", 32'(o_take), 32'd1);
    rd(3'd0);
    chk("R10 entry wins", o_rd, 32'h2);
    chk("R10 epc", eret_target, 32'h200);

    step(0, 1'b1, 3'd2, 32'hFFFF_FFFF, 1'b0, 0);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] irq;
      irq = ($urandom % 4 == 0) ? ($urandom & $urandom & $urandom) : 32'd0;
      step(irq, ($urandom % 6 == 0), 3'($urandom % 6), $urandom,
           ($urandom % 12 == 0), $urandom);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule